// File: doc/BRIEF.md
# Interrupt Timestamp Capture Unit

This block measures interrupt latency for one chosen interrupt line. A free-running tick counter runs from reset. When the chosen line in the pending vector goes from low to high, the counter value is copied into an assertion stamp. When the processor later reports that it has taken that same interrupt, the counter value is copied into an acknowledge stamp. Software reads both stamps and subtracts one from the other.

A single control word selects the line and the capture policy, and it carries two sticky flags that software clears by writing ones. In hold-first policy, the first pair of stamps is frozen until software has cleared both flags. In follow-latest policy, every new rising edge replaces the assertion stamp and re-arms the acknowledge stamp, so the acknowledge stamp always belongs to the most recent event.

Top module: `its_stamp_unit`

## Requirements
- R1: After reset, the control word reads 0x2000_0000 (set count 4 in bits 31:27, all other bits 0), and both stamp words read 0.
- R2: The tick counter is 0 while reset is held and rises by one on every later clock edge. A captured stamp equals the number of clock edges after reset that come before the edge that captures it.
- R3: When the selected bit of the pending vector is sampled high after being low (a rising edge), the assertion stamp is captured and the assertion flag (control bit 26) goes to 1.
- R4: An acknowledge strobe whose number equals the select field (control bits 4:0) is stamped when the assertion flag is 1 and the acknowledge flag (control bit 25) is 0. It sets bit 25. An acknowledge carrying any other number is ignored.
- R5: Writing 1 to control bit 26 or bit 25 clears that flag. Writing 0 leaves it unchanged. The same write loads the policy bit (bit 5) and the select field.
- R6: With bit 5 set to 1 (hold-first), a rising edge is stamped only while both flags are 0. Later edges and acknowledges leave both stamps unchanged until software has cleared both flags.
- R7: With bit 5 set to 0 (follow-latest), every rising edge of the selected line overwrites the assertion stamp and clears bit 25, so the next matching acknowledge is stamped again. Once bit 25 is set, further acknowledges with no new edge are ignored.
- R8: A select field of 0 disables stamping. No edge and no acknowledge changes any flag or stamp.
- R9: When a hardware set of a flag and a software write-one-clear of that flag fall on the same clock edge, the flag ends at 1.
- R10: Register offsets (word index on the address port): 0 is control, 1 is assertion stamp, 2 is acknowledge stamp, 3 reads 0. Read data appears on the clock edge after the address is presented. Bits 24:6 read 0, and writes to bits 31:27 have no effect.
- R11: A selected line held high produces exactly one capture. No new stamp occurs until the line has been low for at least one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 32 | Interrupt pending vector, one bit per line |
| ack_valid | input | 1 | Processor acknowledge strobe, one cycle |
| ack_num | input | 5 | Number of the interrupt being acknowledged |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous address |

## Verification
The bench targets three cases. In one, a write-one-clear lands on the same edge as a new rising edge, and a design that lets the clear win loses the event. In the second, hold-first policy has only one flag cleared, and a design that re-arms on a single clear overwrites the frozen stamp. In the third, follow-latest policy receives a second acknowledge with no new edge in between, and a design that keeps stamping would move the acknowledge stamp past the real first acknowledge. It also checks mismatched acknowledge numbers, a select of 0, and a line held high across a flag clear, where a level-sensitive design would stamp again. It then runs seeded random sequences of edges, acknowledges and control writes against a bench model of the counter and flags.

// File: rtl/its_pkg.sv
package its_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned SETS_W  = 5;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_ASTMP = 2'd1;
  localparam logic [IDX_W-1:0] IDX_KSTMP = 2'd2;

  localparam int unsigned BIT_AFLAG = 26;
  localparam int unsigned BIT_KFLAG = 25;
  localparam int unsigned BIT_HOLD  = 5;

  typedef struct packed {
    logic aflag;
    logic kflag;
  } flags_t;

  function automatic logic [REG_W-1:0] pack_ctrl(
    input logic [SETS_W-1:0] sets,
    input flags_t            fl,
    input logic              hold,
    input logic [4:0]        sel
  );
    logic [REG_W-1:0] w;
    w = '0;
    w[31:27]     = sets;
    w[BIT_AFLAG] = fl.aflag;
    w[BIT_KFLAG] = fl.kflag;
    w[BIT_HOLD]  = hold;
    w[4:0]       = sel;
    return w;
  endfunction
endpackage

// File: rtl/its_tick_counter.sv
module its_tick_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tick == $past(tick) + 1'b1);
endmodule

// File: rtl/its_event_detect.sv
module its_event_detect #(
  parameter int unsigned IRQ_N = 32,
  localparam int unsigned SEL_W = $clog2(IRQ_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] pend,
  input  logic [SEL_W-1:0] sel,
  input  logic             ack_valid,
  input  logic [SEL_W-1:0] ack_num,
  output logic             rise_evt,
  output logic             ack_evt
);
  logic [IRQ_N-1:0] prev_q;
  logic [IRQ_N-1:0] rise_vec;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= pend[g];
    end
    assign rise_vec[g] = pend[g] & ~prev_q[g];
  end

  logic sel_live;
  assign sel_live = (sel != '0);
  assign rise_evt = sel_live & rise_vec[sel];
  assign ack_evt  = sel_live & ack_valid & (ack_num == sel);

  a_r11_no_level_retrigger: assert property (@(posedge clk) disable iff (rst)
    ($past(pend[sel]) && !$past(rst) && $stable(sel)) |-> !rise_evt);
endmodule

// File: rtl/its_stamp_capture.sv
module its_stamp_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   tick,
  input  logic               rise_evt,
  input  logic               ack_evt,
  input  logic               hold,
  input  its_pkg::flags_t    clr,
  output its_pkg::flags_t    flags,
  output logic [CNT_W-1:0]   astamp,
  output logic [CNT_W-1:0]   kstamp
);
  logic a_go;
  logic k_go;
  its_pkg::flags_t flags_n;

  assign a_go = rise_evt & (hold ? (~flags.aflag & ~flags.kflag) : 1'b1);
  assign k_go = ack_evt & flags.aflag & ~flags.kflag & ~a_go;

  always_comb begin
    flags_n = flags;
    if (clr.aflag) flags_n.aflag = 1'b0;
    if (clr.kflag) flags_n.kflag = 1'b0;
    if (a_go) begin
      flags_n.aflag = 1'b1;
      if (!hold) flags_n.kflag = 1'b0;
    end
    if (k_go) flags_n.kflag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      astamp <= '0;
      kstamp <= '0;
    end else begin
      flags <= flags_n;
      if (a_go) astamp <= tick;
      if (k_go) kstamp <= tick;
    end
  end

  a_r3_aflag_from_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.aflag) |-> $past(rise_evt));
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (hold && (flags.aflag || flags.kflag)) |=> $stable(astamp));
  a_r7_rearm_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!hold && rise_evt) |=> (flags.aflag && !flags.kflag));
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && clr.aflag) |=> flags.aflag);
endmodule

// File: rtl/its_stamp_unit.sv
module its_stamp_unit #(
  parameter int unsigned IRQ_N   = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_SETS  = 4,
  localparam int unsigned SEL_W  = $clog2(IRQ_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_pend,
  input  logic             ack_valid,
  input  logic [SEL_W-1:0] ack_num,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  import its_pkg::*;

  logic [CNT_W-1:0] tick;
  logic [SEL_W-1:0] sel_q;
  logic             hold_q;
  logic             rise_evt;
  logic             ack_evt;
  flags_t           flags;
  flags_t           clr;
  logic [CNT_W-1:0] astamp;
  logic [CNT_W-1:0] kstamp;
  logic             ctrl_wr;
  logic             unused_wbits;

  assign ctrl_wr      = reg_we && (reg_addr == IDX_CTRL);
  assign clr.aflag    = ctrl_wr & reg_wdata[BIT_AFLAG];
  assign clr.kflag    = ctrl_wr & reg_wdata[BIT_KFLAG];
  assign unused_wbits = ^{reg_wdata[31:27], reg_wdata[24:6]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      hold_q <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q  <= reg_wdata[SEL_W-1:0];
      hold_q <= reg_wdata[BIT_HOLD];
    end
  end

  its_tick_counter #(.CNT_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  its_event_detect #(.IRQ_N(IRQ_N)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pend      (irq_pend),
    .sel       (sel_q),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .rise_evt  (rise_evt),
    .ack_evt   (ack_evt)
  );

  its_stamp_capture #(.CNT_W(CNT_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rise_evt (rise_evt),
    .ack_evt  (ack_evt),
    .hold     (hold_q),
    .clr      (clr),
    .flags    (flags),
    .astamp   (astamp),
    .kstamp   (kstamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        IDX_CTRL:  reg_rdata <= pack_ctrl(SETS_W'(N_SETS), flags, hold_q, 5'(sel_q));
        IDX_ASTMP: reg_rdata <= 32'(astamp);
        IDX_KSTMP: reg_rdata <= 32'(kstamp);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  a_r4_ack_number_match: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.kflag) |-> $past(ack_valid && ack_num == sel_q && sel_q != '0));
  a_r8_null_select: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |=> !$rose(flags.aflag));
  a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !reg_wdata[BIT_AFLAG] && flags.aflag) |=> flags.aflag);
endmodule

// File: tb/its_stamp_unit_test.sv
module its_stamp_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_pend = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_num = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  its_stamp_unit uut (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .ack_valid(ack_valid),
    .ack_num(ack_num), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // reference tick: mirrors the R2 counting rule
  logic [31:0] cyc;
  always_ff @(posedge clk) cyc <= rst ? 32'd0 : cyc + 32'd1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit m_af, m_kf, m_hold;
  logic [4:0]  m_sel;
  logic [31:0] m_as, m_ks;

  function automatic logic [31:0] exp_ctrl();
    return {5'd4, m_af, m_kf, 19'd0, m_hold, m_sel};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d, exp, tag);
  endtask

  task automatic chk_all(input string tag);
    rd_chk(2'd0, exp_ctrl(), {tag, " ctrl"});
    rd_chk(2'd1, m_as, {tag, " astamp"});
    rd_chk(2'd2, m_ks, {tag, " kstamp"});
  endtask

  function automatic void model_write(input logic [31:0] w);
    if (w[26]) m_af = 0;
    if (w[25]) m_kf = 0;
    m_hold = w[5];
    m_sel  = w[4:0];
  endfunction

  function automatic void model_edge(input int line, input logic [31:0] t);
    bit go;
    if (m_sel == 0 || line != m_sel) return;
    go = m_hold ? (!m_af && !m_kf) : 1'b1;
    if (go) begin
      m_as = t; m_af = 1;
      if (!m_hold) m_kf = 0;
    end
  endfunction

  function automatic void model_ack(input logic [4:0] num, input logic [31:0] t);
    if (m_sel != 0 && num == m_sel && m_af && !m_kf) begin
      m_ks = t; m_kf = 1;
    end
  endfunction

  task automatic wr_ctrl(input logic [31:0] w);
    @(negedge clk);
    reg_we = 1; reg_addr = 2'd0; reg_wdata = w;
    model_write(w);
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic raise(input int line, input int hold_cyc);
    @(negedge clk);
    irq_pend[line] = 1'b1;
    model_edge(line, cyc);
    repeat (hold_cyc) @(negedge clk);
    irq_pend[line] = 1'b0;
  endtask

  task automatic ack(input logic [4:0] num);
    @(negedge clk);
    ack_valid = 1; ack_num = num;
    model_ack(num, cyc);
    @(negedge clk);
    ack_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_af = 0; m_kf = 0; m_hold = 0; m_sel = 0; m_as = 0; m_ks = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 / R10 reset values and map
    rd_chk(2'd0, 32'h2000_0000, "R1 ctrl reset");
    rd_chk(2'd1, 32'd0, "R1 astamp reset");
    rd_chk(2'd2, 32'd0, "R1 kstamp reset");
    rd_chk(2'd3, 32'd0, "R10 spare offset");

    // R8 select 0 stamps nothing
    raise(3, 2); ack(5'd3); ack(5'd0);
    chk_all("R8 null select");

    // R10 read-only bits ignore writes
    wr_ctrl(32'hFFC0_0007 & ~32'h0600_0000);
    rd_chk(2'd0, exp_ctrl(), "R10 ro bits");

    // R2 / R3 first capture, follow-latest
    raise(7, 1);
    chk_all("R2 R3 first edge");
    // R4 mismatched number ignored, matching stamped
    ack(5'd5);
    chk_all("R4 wrong number");
    ack(5'd7);
    chk_all("R4 matching ack");
    // R7 second ack ignored, new edge re-arms
    ack(5'd7);
    chk_all("R7 extra ack");
    raise(7, 3);
    chk_all("R7 rearm edge");
    ack(5'd7);
    chk_all("R7 restamp ack");

    // R5 write-one-clear
    wr_ctrl(32'h0400_0007);
    chk_all("R5 clear aflag");
    wr_ctrl(32'h0000_0007);
    chk_all("R5 zero write");
    wr_ctrl(32'h0200_0007);
    chk_all("R5 clear kflag");

    // R11 held line does not retrigger
    @(negedge clk); irq_pend[7] = 1'b1; model_edge(7, cyc);
    repeat (2) @(negedge clk);
    wr_ctrl(32'h0600_0007);
    repeat (5) @(negedge clk);
    chk_all("R11 held level");
    irq_pend[7] = 1'b0;
    @(negedge clk);

    // R6 hold-first
    wr_ctrl(32'h0600_0027);
    raise(7, 1); ack(5'd7);
    chk_all("R6 first pair");
    raise(7, 1); ack(5'd7);
    chk_all("R6 frozen");
    wr_ctrl(32'h0400_0027);
    raise(7, 1);
    chk_all("R6 one flag cleared");
    wr_ctrl(32'h0200_0027);
    raise(7, 2);
    chk_all("R6 both cleared");

    // R9 set wins over clear on the same edge
    wr_ctrl(32'h0000_0007);
    @(negedge clk);
    irq_pend[7] = 1'b1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h0400_0007;
    model_write(32'h0400_0007);
    model_edge(7, cyc);
    @(negedge clk);
    reg_we = 0; irq_pend[7] = 1'b0;
    chk_all("R9 set beats clear");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      logic [4:0] pick [4];
      pick[0] = 5'd0; pick[1] = 5'd7; pick[2] = 5'd12; pick[3] = 5'd31;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        int ln;
        ln = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 31) : m_sel;
        raise(ln, $urandom_range(1, 3));
      end else if (op < 8) begin
        ack(($urandom_range(0, 2) == 0) ? 5'($urandom_range(0, 31)) : m_sel);
      end else begin
        logic [31:0] w;
        w = $urandom;
        w[4:0] = pick[$urandom_range(0, 3)];
        wr_ctrl(w);
      end
      repeat ($urandom_range(0, 4)) @(negedge clk);
      chk_all($sformatf("R2 R4 R6 R7 random step %0d", i));
    end

    rd(2'd3, d);
    chk(d, 32'd0, "R10 spare final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule